// File: doc/BRIEF.md
# Processor Address Map Decoder

This block sits between a processor with a 16-bit address bus and 8-bit data and the storage that bus reaches. It splits the address space into fixed windows: a read-only program area with a start-up overlay, a graphics memory, an unpopulated expansion window, a general working memory with an alias window above it, a sprite attribute table, a small register file for peripherals, a fast scratch area and one interrupt mask register. Reads are combinational: the data byte follows the address and the stored contents in the same cycle. Writes land on the rising clock edge while the write strobe is high.

The program area and the start-up overlay are generated from a multiply-and-add pattern selected by parameters, so a bench can predict every byte without loading files. The start-up overlay covers the lowest bytes of the program area until one write to its disable address turns it off for the rest of the run. Some register addresses follow special rules: one always reads as all ones, one stores zero when the processor runs in user mode, and one write value to the serial control address sends the serial data byte out on a debug port for one cycle. Several unused gaps answer with their own fixed values and drop writes.

Top module: `busdec_top`

## Requirements
- R1: For addresses 0x0000 to 0x7FFF, rdata is the overlay byte (a*13 + 0xC3) mod 256 when the overlay is enabled and a < 64; otherwise it is the program byte ((a mod 256)*7 + 0x5A) mod 256.
- R2: A write of any data to 0xFF50 disables the overlay; it stays disabled until the next reset, and the program bytes then read at 0x0000 to 0x003F.
- R3: Writes into 0x0000 to 0x7FFF, 0xA000 to 0xBFFF, 0xFEA0 to 0xFEFF and 0xFF4C to 0xFF7F change no readable byte; 0xA000 to 0xBFFF and 0xFF4C to 0xFF7F read 0xFF and 0xFEA0 to 0xFEFF reads 0x00.
- R4: 0x8000 to 0x9FFF is graphics memory of 2^VRAM_AW bytes (256 by default) indexed by the low address bits, so a byte written is read back at every alias.
- R5: 0xC000 to 0xDFFF is working memory of 2^WRAM_AW bytes (256 by default) indexed by the low address bits; 0xE000 to 0xFDFF reaches the same byte as the address minus 0x2000, for reads and writes.
- R6: 0xFE00 to 0xFE9F is a 160-byte attribute table that keeps each written byte.
- R7: 0xFF01 to 0xFF4B are writable registers that reset to 0xFF; 0xFF00 always reads 0xFF whatever was written.
- R8: A write to 0xFF04 stores 0x00 while user_mode is 1 and the written data while user_mode is 0.
- R9: 0xFF80 to 0xFFFE is a 127-byte scratch memory; 0xFFFF is a separate interrupt mask register that resets to 0x00.
- R10: A write of 0x81 to 0xFF02 raises dbg_valid for exactly the next cycle with dbg_byte equal to the value held at 0xFF01 before that write; any other write leaves dbg_valid low.
- R11: A synchronous reset (rst_n low at a clock edge) clears all memories and the interrupt mask to 0x00, sets the registers to 0xFF, re-enables the overlay and holds dbg_valid low.
- R12: rdata is a pure function of addr and the stored contents: it changes with addr with no clock edge, and a write becomes readable after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, sampled at the rising edge |
| user_mode | input | 1 | Selects the zeroing rule for writes to 0xFF04 |
| rdata | output | 8 | Combinational read data for addr |
| dbg_valid | output | 1 | One-cycle strobe for a serial debug byte |
| dbg_byte | output | 8 | Serial debug byte, meaningful while dbg_valid is high |

## Verification
The assertions take for granted that addr, wdata, we and user_mode are stable around each rising edge and that rst_n is held low from time zero until the first edges have passed, so the state they observe is always defined. The bench drives every input on the falling edge, keeps we low during every read sweep so that the read data can only depend on the address, and raises the write strobe for one edge per write. Read sweeps step the address with no clock dependence and cover all 65536 addresses, so both overlay states and every gap are compared against the bench's own model.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    localparam int OAM_BYTES  = 160;
    localparam int IO_BYTES   = 76;
    localparam int HRAM_BYTES = 127;

    localparam logic [15:0] A_JOY      = 16'hFF00;
    localparam logic [15:0] A_SER_DATA = 16'hFF01;
    localparam logic [15:0] A_SER_CTRL = 16'hFF02;
    localparam logic [15:0] A_DIV      = 16'hFF04;
    localparam logic [15:0] A_BOOT_OFF = 16'hFF50;
    localparam logic [7:0]  SER_GO     = 8'h81;

    typedef enum logic [3:0] {
        RG_ROM,
        RG_VRAM,
        RG_XRAM,
        RG_WRAM,
        RG_ECHO,
        RG_OAM,
        RG_GAP_LO,
        RG_IO,
        RG_GAP_HI,
        RG_HRAM,
        RG_IE
    } region_e;

    function automatic logic [7:0] pattern_byte(input logic [15:0] idx,
                                                input logic [7:0]  mul,
                                                input logic [7:0]  seed);
        logic [23:0] t;
        t = 24'(idx) * 24'(mul) + 24'(seed);
        return t[7:0];
    endfunction

endpackage

// File: rtl/busdec_region.sv
module busdec_region
    import busdec_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     region
);

    always_comb begin
        if (addr < 16'h8000) begin
            region = RG_ROM;
        end else if (addr < 16'hA000) begin
            region = RG_VRAM;
        end else if (addr < 16'hC000) begin
            region = RG_XRAM;
        end else if (addr < 16'hE000) begin
            region = RG_WRAM;
        end else if (addr < 16'hFE00) begin
            region = RG_ECHO;
        end else if (addr < 16'hFEA0) begin
            region = RG_OAM;
        end else if (addr < 16'hFF00) begin
            region = RG_GAP_LO;
        end else if (addr < 16'hFF4C) begin
            region = RG_IO;
        end else if (addr < 16'hFF80) begin
            region = RG_GAP_HI;
        end else if (addr != 16'hFFFF) begin
            region = RG_HRAM;
        end else begin
            region = RG_IE;
        end
    end

endmodule

// File: rtl/busdec_ram.sv
module busdec_ram #(
    parameter int AW    = 8,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int SLOTS = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we && (int'(waddr) < DEPTH)) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // A depth that fills the index space needs no range guard on reads.
    generate
        if (DEPTH == SLOTS) begin : g_full
            assign rdata = mem_q[raddr];
        end else begin : g_part
            assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/busdec_regs.sv
module busdec_regs
    import busdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  region_e     region,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        user_mode,
    output logic [7:0]  io_rdata,
    output logic [7:0]  ie_rdata,
    output logic        boot_en,
    output logic        dbg_valid,
    output logic [7:0]  dbg_byte
);

    localparam int IO_IW = $clog2(IO_BYTES);
    localparam logic [IO_IW-1:0] SER_IDX = A_SER_DATA[IO_IW-1:0];

    typedef struct packed {
        logic [IO_BYTES-1:0][7:0] io;
        logic [7:0]               ie;
        logic                     boot_en;
        logic                     ser_v;
        logic [7:0]               ser_b;
    } regs_t;

    regs_t r_q, r_d;
    logic [IO_IW-1:0] io_idx;

    assign io_idx = addr[IO_IW-1:0];

    always_comb begin
        r_d       = r_q;
        r_d.ser_v = 1'b0;
        if (we) begin
            case (region)
                RG_IO: begin
                    if (addr == A_DIV) begin
                        r_d.io[io_idx] = user_mode ? 8'h00 : wdata;
                    end else begin
                        r_d.io[io_idx] = wdata;
                    end
                    if ((addr == A_SER_CTRL) && (wdata == SER_GO)) begin
                        r_d.ser_v = 1'b1;
                        r_d.ser_b = r_q.io[SER_IDX];
                    end
                end
                RG_GAP_HI: begin
                    if (addr == A_BOOT_OFF) begin
                        r_d.boot_en = 1'b0;
                    end
                end
                RG_IE: begin
                    r_d.ie = wdata;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.io      <= '1;
            r_q.ie      <= 8'h00;
            r_q.boot_en <= 1'b1;
            r_q.ser_v   <= 1'b0;
            r_q.ser_b   <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (addr == A_JOY) begin
            io_rdata = 8'hFF;
        end else if (int'(io_idx) < IO_BYTES) begin
            io_rdata = r_q.io[io_idx];
        end else begin
            io_rdata = 8'hFF;
        end
    end

    assign ie_rdata  = r_q.ie;
    assign boot_en   = r_q.boot_en;
    assign dbg_valid = r_q.ser_v;
    assign dbg_byte  = r_q.ser_b;

endmodule

// File: rtl/busdec_top.sv
module busdec_top
    import busdec_pkg::*;
#(
    parameter int         VRAM_AW   = 8,
    parameter int         WRAM_AW   = 8,
    parameter int         ROM_AW    = 8,
    parameter int         BOOT_LEN  = 64,
    parameter logic [7:0] CART_MUL  = 8'd7,
    parameter logic [7:0] CART_SEED = 8'h5A,
    parameter logic [7:0] BOOT_MUL  = 8'd13,
    parameter logic [7:0] BOOT_SEED = 8'hC3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        we,
    input  logic        user_mode,
    output logic [7:0]  rdata,
    output logic        dbg_valid,
    output logic [7:0]  dbg_byte
);

    localparam int          OAM_AW   = $clog2(OAM_BYTES);
    localparam int          HRAM_AW  = $clog2(HRAM_BYTES + 1);
    localparam logic [15:0] ROM_MASK = 16'((1 << ROM_AW) - 1);
    localparam logic [15:0] BOOT_TOP = 16'(BOOT_LEN);

    region_e    region;
    logic       boot_en;
    logic [7:0] vram_rd, wram_rd, oam_rd, hram_rd, io_rd, ie_rd;
    logic [7:0] rom_rd;
    logic       vram_we, wram_we, oam_we, hram_we;

    busdec_region u_region (
        .addr   (addr),
        .region (region)
    );

    assign vram_we = we && (region == RG_VRAM);
    assign wram_we = we && ((region == RG_WRAM) || (region == RG_ECHO));
    assign oam_we  = we && (region == RG_OAM);
    assign hram_we = we && (region == RG_HRAM);

    busdec_ram #(.AW(VRAM_AW), .DEPTH(1 << VRAM_AW)) u_vram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vram_we),
        .waddr (addr[VRAM_AW-1:0]),
        .wdata (wdata),
        .raddr (addr[VRAM_AW-1:0]),
        .rdata (vram_rd)
    );

    // The alias window sits 0x2000 above, so the low bits already match.
    busdec_ram #(.AW(WRAM_AW), .DEPTH(1 << WRAM_AW)) u_wram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wram_we),
        .waddr (addr[WRAM_AW-1:0]),
        .wdata (wdata),
        .raddr (addr[WRAM_AW-1:0]),
        .rdata (wram_rd)
    );

    busdec_ram #(.AW(OAM_AW), .DEPTH(OAM_BYTES)) u_oam (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (oam_we),
        .waddr (addr[OAM_AW-1:0]),
        .wdata (wdata),
        .raddr (addr[OAM_AW-1:0]),
        .rdata (oam_rd)
    );

    busdec_ram #(.AW(HRAM_AW), .DEPTH(HRAM_BYTES)) u_hram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hram_we),
        .waddr (addr[HRAM_AW-1:0]),
        .wdata (wdata),
        .raddr (addr[HRAM_AW-1:0]),
        .rdata (hram_rd)
    );

    busdec_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .region    (region),
        .addr      (addr),
        .wdata     (wdata),
        .user_mode (user_mode),
        .io_rdata  (io_rd),
        .ie_rdata  (ie_rd),
        .boot_en   (boot_en),
        .dbg_valid (dbg_valid),
        .dbg_byte  (dbg_byte)
    );

    always_comb begin
        if (boot_en && (addr < BOOT_TOP)) begin
            rom_rd = pattern_byte(addr, BOOT_MUL, BOOT_SEED);
        end else begin
            rom_rd = pattern_byte(addr & ROM_MASK, CART_MUL, CART_SEED);
        end
    end

    always_comb begin
        case (region)
            RG_ROM:    rdata = rom_rd;
            RG_VRAM:   rdata = vram_rd;
            RG_XRAM:   rdata = 8'hFF;
            RG_WRAM:   rdata = wram_rd;
            RG_ECHO:   rdata = wram_rd;
            RG_OAM:    rdata = oam_rd;
            RG_GAP_LO: rdata = 8'h00;
            RG_IO:     rdata = io_rd;
            RG_GAP_HI: rdata = 8'hFF;
            RG_HRAM:   rdata = hram_rd;
            RG_IE:     rdata = ie_rd;
            default:   rdata = 8'hFF;
        endcase
    end

endmodule

// File: rtl/busdec_chk.sv
module busdec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic [7:0]  wdata,
    input logic        we,
    input logic        user_mode,
    input logic [7:0]  rdata,
    input logic        dbg_valid,
    input logic        boot_en
);

    // R10: a debug strobe only follows the serial start write
    a_r10_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_valid |-> $past(we && (addr == 16'hFF02) && (wdata == 8'h81)));

    // R10: the serial start write always produces the strobe
    a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == 16'hFF02) && (wdata == 8'h81)) |=> dbg_valid);

    // R2: once off, the overlay stays off
    a_r2_overlay_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_en |=> !boot_en);

    // R2: the disable address turns the overlay off
    a_r2_overlay_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == 16'hFF50)) |=> !boot_en);

    // R3: expansion window reads all ones
    a_r3_xram_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr >= 16'hA000) && (addr < 16'hC000)) |-> (rdata == 8'hFF));

    // R3: gap above the attribute table reads zero
    a_r3_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr >= 16'hFEA0) && (addr < 16'hFF00)) |-> (rdata == 8'h00));

    // R3: a write into the program area leaves the byte unchanged
    a_r3_rom_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !addr[15]) |=> ((addr != $past(addr)) || (rdata == $past(rdata))));

    // R7: the first register address always reads all ones
    a_r7_joy_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 16'hFF00) |-> (rdata == 8'hFF));

    // R8: in user mode the divider write stores zero
    a_r8_div_user_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we && user_mode && (addr == 16'hFF04)) |=> ((addr != 16'hFF04) || (rdata == 8'h00)));

endmodule

bind busdec_top busdec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wdata     (wdata),
    .we        (we),
    .user_mode (user_mode),
    .rdata     (rdata),
    .dbg_valid (dbg_valid),
    .boot_en   (boot_en)
);

// File: tb/sim_busdec_top.sv
module sim_busdec_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        we;
    logic        user_mode;
    logic [7:0]  rdata;
    logic        dbg_valid;
    logic [7:0]  dbg_byte;

    always #4 clk = ~clk;

    busdec_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wdata     (wdata),
        .we        (we),
        .user_mode (user_mode),
        .rdata     (rdata),
        .dbg_valid (dbg_valid),
        .dbg_byte  (dbg_byte)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_vram [256];
    logic [7:0] m_wram [256];
    logic [7:0] m_oam  [160];
    logic [7:0] m_io   [76];
    logic [7:0] m_hram [127];
    logic [7:0] m_ie;
    logic       m_boot;
    logic       m_sv;
    logic [7:0] m_sb;

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin m_vram[i] = 8'h00; m_wram[i] = 8'h00; end
        for (int i = 0; i < 160; i++) m_oam[i] = 8'h00;
        for (int i = 0; i < 76; i++) m_io[i] = 8'hFF;
        for (int i = 0; i < 127; i++) m_hram[i] = 8'h00;
        m_ie = 8'h00;
        m_boot = 1'b1;
    endtask

    function automatic logic [7:0] exp_rd(int a);
        if (a < 32'h8000) begin
            if (m_boot && a < 64) return 8'((a * 13 + 32'hC3) % 256);
            return 8'(((a % 256) * 7 + 32'h5A) % 256);
        end
        if (a < 32'hA000) return m_vram[a % 256];
        if (a < 32'hC000) return 8'hFF;
        if (a < 32'hFE00) return m_wram[a % 256];
        if (a < 32'hFEA0) return m_oam[a - 32'hFE00];
        if (a < 32'hFF00) return 8'h00;
        if (a == 32'hFF00) return 8'hFF;
        if (a < 32'hFF4C) return m_io[a - 32'hFF00];
        if (a < 32'hFF80) return 8'hFF;
        if (a < 32'hFFFF) return m_hram[a - 32'hFF80];
        return m_ie;
    endfunction

    function automatic string req_of(int a);
        if (a < 32'h8000) return "R1";
        if (a < 32'hA000) return "R4";
        if (a < 32'hC000) return "R3";
        if (a < 32'hFE00) return "R5";
        if (a < 32'hFEA0) return "R6";
        if (a < 32'hFF00) return "R3";
        if (a == 32'hFF04) return "R8";
        if (a < 32'hFF4C) return "R7";
        if (a < 32'hFF80) return "R3";
        return "R9";
    endfunction

    task automatic model_write(int a, logic [7:0] d, logic um);
        m_sv = 1'b0;
        if (a >= 32'h8000 && a < 32'hA000) m_vram[a % 256] = d;
        else if (a >= 32'hC000 && a < 32'hFE00) m_wram[a % 256] = d;
        else if (a >= 32'hFE00 && a < 32'hFEA0) m_oam[a - 32'hFE00] = d;
        else if (a >= 32'hFF00 && a < 32'hFF4C) begin
            if (a == 32'hFF02 && d == 8'h81) begin m_sv = 1'b1; m_sb = m_io[1]; end
            m_io[a - 32'hFF00] = (a == 32'hFF04 && um) ? 8'h00 : d;
        end
        else if (a == 32'hFF50) m_boot = 1'b0;
        else if (a >= 32'hFF80 && a < 32'hFFFF) m_hram[a - 32'hFF80] = d;
        else if (a == 32'hFFFF) m_ie = d;
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, int a);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%04h actual=%02h expected=%02h", req, a, act, exp);
        end
    endtask

    // R12: reads step the address with no clock dependence
    task automatic sweep();
        we = 1'b0;
        for (int a = 0; a < 65536; a++) begin
            addr = 16'(a);
            #1;
            check(req_of(a), rdata, exp_rd(a), a);
        end
    endtask

    // R10: every write is followed by a strobe check one cycle later
    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        addr = 16'(a);
        wdata = d;
        we = 1'b1;
        @(posedge clk);
        model_write(a, d, user_mode);
        @(negedge clk);
        we = 1'b0;
        #1;
        check("R10", {7'd0, dbg_valid}, {7'd0, m_sv}, a);
        if (m_sv) check("R10", dbg_byte, m_sb, a);
    endtask

    function automatic logic [7:0] dv(int a);
        return 8'((a ^ (a >> 8) ^ 32'h5C) % 256);
    endfunction

    task automatic wr_range(int lo, int hi);
        for (int a = lo; a <= hi; a++) wr(a, dv(a));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        m_sv = 1'b0;
        #1;
        check("R11", {7'd0, dbg_valid}, 8'd0, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        addr = 16'h0000;
        wdata = 8'h00;
        we = 1'b0;
        user_mode = 1'b0;
        m_sv = 1'b0;
        m_sb = 8'h00;
        model_reset();
        do_reset();
        // R11 and R1 with the overlay enabled
        sweep();

        // R3 R4 R5 R6 R7 R9: fill every writable window and touch the dead ones
        wr_range(32'h0000, 32'h00FF);
        wr_range(32'h7F00, 32'h7FFF);
        wr_range(32'h8000, 32'h9FFF);
        wr_range(32'hA000, 32'hA0FF);
        wr_range(32'hC000, 32'hFDFF);
        wr_range(32'hFE00, 32'hFF4F);
        sweep();

        // R8: user-mode divider write stores zero, normal mode stores data
        user_mode = 1'b1;
        wr(32'hFF04, 8'h77);
        addr = 16'hFF04; #1;
        check("R8", rdata, 8'h00, 32'hFF04);
        user_mode = 1'b0;
        wr(32'hFF04, 8'h39);
        addr = 16'hFF04; #1;
        check("R8", rdata, 8'h39, 32'hFF04);

        // R10: serial start emits the previous data byte for one cycle
        wr(32'hFF01, 8'h3C);
        wr(32'hFF02, 8'h81);
        @(negedge clk); #1;
        check("R10", {7'd0, dbg_valid}, 8'd0, 32'hFF02);
        wr(32'hFF02, 8'h80);

        // R5: mirror write lands in working memory
        wr(32'hE0AB, 8'h5E);
        addr = 16'hC0AB; #1;
        check("R5", rdata, 8'h5E, 32'hC0AB);

        // R2: disable the overlay with zero data, then fill the upper addresses
        wr(32'hFF50, 8'h00);
        addr = 16'h0000; #1;
        check("R2", rdata, 8'h5A, 0);
        wr_range(32'hFF51, 32'hFFFF);
        sweep();

        // R11: reset restores every store and the overlay
        do_reset();
        sweep();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule